// File: doc/BRIEF.md
# TDM PCM Port Time-Slot Assigner

This block is the serial voice port of a telephony codec. It watches a bit clock and a frame sync, finds the assigned time slot in each frame and moves one voice word per frame in each direction. On the transmit side it sends a 14-bit linear word or an 8-bit companded word, MSB first. The transmit pin is modelled as a data line `dx` plus a pad enable `dx_oe`. On the receive side it assembles a word of the same length from `dr` and hands it to the parallel side with a one-cycle strobe.

The bit clock, frame sync and receive pin are oversampled by the fast system clock `clk` through a two-stage synchronizer. A slot timer counts bit periods from the frame start. A four-state power FSM decides when the port may drive the line. The states are `PS_DOWN` (powered down), `PS_ARM1` (powered, no frame sync seen yet), `PS_ARM2` (one frame sync seen) and `PS_RUN` (port live). The transitions are:
- `PS_DOWN`→`PS_ARM1` when `pwr_up` is high.
- `PS_ARM1`→`PS_ARM2` on a frame-sync rising edge.
- `PS_ARM2`→`PS_RUN` on the next frame-sync rising edge.
- Any state→`PS_DOWN` when `pwr_up` is low.

The transmit word is latched at each frame start, and `tx_take` pulses when this happens. In loopback the word latched is the last received word instead of `tx_word`.

Top module: `pcm_tsa_port`

## Requirements
- R1: After reset, and while `pwr_up` is low, `dx_oe` and `rx_valid` are low.
- R2: A frame starts only on a rising edge of `fsync` seen at a launch edge. The width of the `fsync` high time, from one bit period up to a square wave, has no effect on frame timing.
- R3: `tmode[1]`=0 selects delayed timing: bit 0 begins one bit period after the launch edge at which `fsync` is first seen high. `tmode`=2'b10 selects non-delayed normal timing: bit 0 begins at the rising `bclk` edge that first sees `fsync` high; `dx` changes on rising edges and `dr` is sampled on falling edges. `tmode`=2'b11 selects non-delayed reverse timing: `dx` changes on falling edges and `dr` is sampled on rising edges, with bit 0 launched on the first falling edge that sees `fsync` high.
- R4: With `companded`=0, the slot is bit positions 0..13 and carries `tx_word[13:0]` MSB first. `sel_b2`, `layout2` and `seven_bit` have no effect in this mode.
- R5: With `companded`=1, the slot is 8 bits long and carries `tx_word[7:0]` MSB first. With `sel_b2`=0 the slot occupies positions 0..7. With `sel_b2`=1 it occupies positions 8..15 when `layout2`=0, and positions 10..17 when `layout2`=1.
- R6: `dx_oe` is low outside the selected slot and whenever `port_en` is low. While `port_en` is low, no word is received.
- R7: With `companded`=1 and `seven_bit`=1, `dx_oe` is low during the slot's last bit, and bit 0 of the received word is 0 whatever `dr` carried.
- R8: With `loopback`=1, the word received in one frame is transmitted unchanged in the slot of the next frame.
- R9: After `pwr_up` rises, `dx_oe` stays low and nothing is received until the frame started by the second `fsync` rising edge.
- R10: `rx_valid` is a single-cycle pulse after the slot's last bit is sampled. `rx_word` is zero-extended in companded mode.
- R11: `tx_take` pulses once per frame start, and `tx_word` is latched then. A change of `tx_word` later in the frame does not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `bclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync |
| dr | input | 1 | Serial receive data |
| pwr_up | input | 1 | Power-up command level |
| port_en | input | 1 | Voice transfer enable |
| companded | input | 1 | 1: 8-bit companded words, 0: 14-bit linear |
| layout2 | input | 1 | 1: two-bit gap between B1 and B2 |
| sel_b2 | input | 1 | 1: use slot B2, 0: slot B1 |
| tmode | input | 2 | Frame timing mode (see R3) |
| seven_bit | input | 1 | Drop LSB in companded mode |
| loopback | input | 1 | Send back last received word |
| tx_word | input | 14 | Parallel transmit word |
| tx_take | output | 1 | Pulse when `tx_word` is latched |
| rx_word | output | 14 | Last received word |
| rx_valid | output | 1 | Pulse when `rx_word` is new |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Transmit pad drive enable |

## Verification
A launch edge on the pins reaches `dx` and `dx_oe` after the two synchronizer stages, the edge compare, the slot counter and the output register. That is at most six `clk` cycles, counting the one cycle in which the frame's first bit is reloaded from the freshly latched word. The bench holds each bit-clock half period for eight cycles and samples the pins seven cycles after the edge, so it always reads the settled value of the bit being launched. `rx_valid` follows the last capture edge by about four cycles. The bench counts strobes over the whole frame, which runs several bit periods past every slot, and compares the count and the captured word once the frame is over.

// File: rtl/pcm_tsa_pkg.sv
package pcm_tsa_pkg;
    typedef enum logic [1:0] {
        PS_DOWN = 2'd0,
        PS_ARM1 = 2'd1,
        PS_ARM2 = 2'd2,
        PS_RUN  = 2'd3
    } port_state_t;
endpackage

// File: rtl/pcm_pin_sync.sv
module pcm_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic dr,
    input  logic reverse,
    output logic launch,
    output logic capture,
    output logic fs_lvl,
    output logic dr_lvl
);
    // bit 0: bclk, bit 1: fsync, bit 2: dr
    logic [STAGES-1:0][2:0] pipe;
    logic eff, eff_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe     <= '0;
            eff_prev <= 1'b0;
        end else begin
            pipe     <= {pipe[STAGES-2:0], dr, fsync, bclk};
            eff_prev <= eff;
        end
    end

    // Reverse timing is handled by viewing the bit clock inverted
    assign eff     = pipe[STAGES-1][0] ^ reverse;
    assign launch  = eff & ~eff_prev;
    assign capture = ~eff & eff_prev;
    assign fs_lvl  = pipe[STAGES-1][1];
    assign dr_lvl  = pipe[STAGES-1][2];
endmodule

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             fs_lvl,
    input  logic             delayed,
    output logic [CNT_W-1:0] cnt,
    output logic             frame_start,
    output logic             fs_rise
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic fs_last, pend, fs_edge;

    assign fs_edge = launch & fs_lvl & ~fs_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= CNT_MAX;
            fs_last     <= 1'b0;
            pend        <= 1'b0;
            frame_start <= 1'b0;
            fs_rise     <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            fs_rise     <= 1'b0;
            if (launch) begin
                fs_last <= fs_lvl;
                fs_rise <= fs_edge;
                pend    <= fs_edge & delayed;
                if ((fs_edge && !delayed) || pend) begin
                    cnt         <= '0;
                    frame_start <= 1'b1;
                end else if (cnt != CNT_MAX) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
    parameter int LIN_W = 14,
    parameter int CMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             bit_in,
    input  logic             last,
    input  logic             companded,
    input  logic             seven_bit,
    output logic [LIN_W-1:0] word,
    output logic             valid
);
    logic [LIN_W-2:0] shreg;
    logic [LIN_W-1:0] full, cword;

    always_comb begin
        full               = {shreg, bit_in};
        cword              = '0;
        cword[CMP_W-1:0]   = full[CMP_W-1:0];
        if (seven_bit) cword[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (take) begin
                if (last) begin
                    word  <= companded ? cword : full;
                    valid <= 1'b1;
                end else begin
                    shreg <= full[LIN_W-2:0];
                end
            end
        end
    end

    // R10
    rx_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
endmodule

// File: rtl/pcm_tsa_port.sv
module pcm_tsa_port
    import pcm_tsa_pkg::*;
#(
    parameter int LIN_W       = 14,
    parameter int CMP_W       = 8,
    parameter int GAP_W       = 2,
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk,
    input  logic             fsync,
    input  logic             dr,
    input  logic             pwr_up,
    input  logic             port_en,
    input  logic             companded,
    input  logic             layout2,
    input  logic             sel_b2,
    input  logic [1:0]       tmode,
    input  logic             seven_bit,
    input  logic             loopback,
    input  logic [LIN_W-1:0] tx_word,
    output logic             tx_take,
    output logic [LIN_W-1:0] rx_word,
    output logic             rx_valid,
    output logic             dx,
    output logic             dx_oe
);
    localparam int IDX_W = $clog2(LIN_W);
    localparam logic [CNT_W-1:0] LEN_LIN  = CNT_W'(LIN_W);
    localparam logic [CNT_W-1:0] LEN_CMP  = CNT_W'(CMP_W);
    localparam logic [CNT_W-1:0] BASE_B2  = CNT_W'(CMP_W);
    localparam logic [CNT_W-1:0] BASE_B2G = CNT_W'(CMP_W + GAP_W);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic launch, capture, fs_lvl, dr_lvl;
    logic reverse, delayed;
    logic [CNT_W-1:0] cnt;
    logic frame_start, fs_rise;

    assign reverse = tmode[1] & tmode[0];
    assign delayed = ~tmode[1];

    pcm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .dr(dr),
        .reverse(reverse), .launch(launch), .capture(capture),
        .fs_lvl(fs_lvl), .dr_lvl(dr_lvl)
    );

    pcm_slot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch), .fs_lvl(fs_lvl),
        .delayed(delayed), .cnt(cnt), .frame_start(frame_start), .fs_rise(fs_rise)
    );

    // Power / release state machine
    port_state_t st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            PS_DOWN: if (pwr_up)  st_nx = PS_ARM1;
            PS_ARM1: if (fs_rise) st_nx = PS_ARM2;
            PS_ARM2: if (fs_rise) st_nx = PS_RUN;
            PS_RUN:  st_nx = PS_RUN;
        endcase
        if (!pwr_up) st_nx = PS_DOWN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PS_DOWN;
        else        st <= st_nx;
    end

    // Slot window
    logic [CNT_W-1:0] base, len, pos;
    logic [CNT_W:0]   win_end;
    logic [IDX_W-1:0] idx;
    logic in_slot, last, drop;

    always_comb begin
        len = companded ? LEN_CMP : LEN_LIN;
        if (!companded || !sel_b2) base = '0;
        else if (layout2)          base = BASE_B2G;
        else                       base = BASE_B2;
        win_end = {1'b0, base} + {1'b0, len};
        in_slot = ({1'b0, cnt} >= {1'b0, base}) && ({1'b0, cnt} < win_end);
        pos     = cnt - base;
        last    = in_slot && (pos == (len - ONE));
        drop    = companded && seven_bit && last;
        idx     = IDX_W'(len - ONE - pos);
    end

    // Output process
    logic live;
    logic [LIN_W-1:0] txbuf;
    logic dx_q, oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live  <= 1'b0;
            txbuf <= '0;
            dx_q  <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            if (!pwr_up)          live <= 1'b0;
            else if (frame_start) live <= (st_nx == PS_RUN);
            if (frame_start) txbuf <= loopback ? rx_word : tx_word;
            oe_q <= live && port_en && in_slot && !drop && (st == PS_RUN);
            dx_q <= in_slot ? txbuf[idx] : 1'b0;
        end
    end

    assign dx      = dx_q;
    assign dx_oe   = oe_q;
    assign tx_take = frame_start;

    logic rx_take;
    assign rx_take = capture && live && port_en && in_slot && (st == PS_RUN);

    pcm_rx_deser #(.LIN_W(LIN_W), .CMP_W(CMP_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .take(rx_take), .bit_in(dr_lvl), .last(last),
        .companded(companded), .seven_bit(seven_bit), .word(rx_word), .valid(rx_valid)
    );

    // R6
    tx_off_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !dx_oe);
    // R9
    tx_off_unreleased_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != PS_RUN) |=> !dx_oe);
    // R1
    down_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> (st == PS_DOWN));
    // R7
    seven_lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && companded && seven_bit) |-> !rx_word[0]);
endmodule

// File: tb/sim_pcm_tsa_port.sv
`timescale 1ns/1ps
module sim_pcm_tsa_port;
    localparam int H  = 8;
    localparam int NP = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, fsync = 1'b0, dr = 1'b0;
    logic pwr_up = 1'b0, port_en = 1'b0, companded = 1'b0, layout2 = 1'b0;
    logic sel_b2 = 1'b0, seven_bit = 1'b0, loopback = 1'b0;
    logic [1:0] tmode = 2'b10;
    logic [13:0] tx_word = '0;
    logic tx_take, rx_valid, dx, dx_oe;
    logic [13:0] rx_word;

    int checks = 0, failures = 0;
    int rx_cnt = 0, take_cnt = 0, fs_pulses = 0;
    logic [13:0] rx_seen = '0, last_rx = '0;
    bit done = 0;

    always #5 clk = ~clk;

    pcm_tsa_port u0 (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .dr(dr),
        .pwr_up(pwr_up), .port_en(port_en), .companded(companded), .layout2(layout2),
        .sel_b2(sel_b2), .tmode(tmode), .seven_bit(seven_bit), .loopback(loopback),
        .tx_word(tx_word), .tx_take(tx_take), .rx_word(rx_word), .rx_valid(rx_valid),
        .dx(dx), .dx_oe(dx_oe)
    );

    always @(posedge clk) begin
        if (rx_valid) begin rx_cnt <= rx_cnt + 1; rx_seen <= rx_word; end
        if (tx_take) take_cnt <= take_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame: fsync rises at period 1 and stays high for fsw periods
    task automatic run_frame(input int fsw, input logic [13:0] txw, input logic [13:0] drw, input string req);
        int blen, bbase, k, pos;
        bit live, ins, lst, exp_oe, launch_half;
        logic [13:0] exp_tx, exp_rx;
        blen  = companded ? 8 : 14;
        bbase = (!companded || !sel_b2) ? 0 : (layout2 ? 10 : 8);
        if (pwr_up) fs_pulses++;
        live   = pwr_up && port_en && (fs_pulses >= 2);
        exp_tx = loopback ? last_rx : txw;
        tx_word = txw;
        @(negedge clk);
        rx_cnt = 0; take_cnt = 0;
        for (int h = 0; h < 2*NP; h++) begin
            int p;
            p = h / 2;
            bclk = (h % 2 == 0);
            if (h % 2 == 0) fsync = (p >= 1) && (p < 1 + fsw);
            if (tmode == 2'b11) begin launch_half = (h % 2 == 1); k = p - 1; end
            else if (tmode[1])  begin launch_half = (h % 2 == 0); k = p - 1; end
            else                begin launch_half = (h % 2 == 0); k = p - 2; end
            pos = k - bbase;
            ins = (k >= bbase) && (k < bbase + blen);
            lst = ins && (pos == blen - 1);
            if (launch_half) begin
                dr = ins ? drw[blen-1-pos] : 1'b1;
                if (k == 2) tx_word = ~txw;  // R11: late change must not matter
            end
            wclk(H - 1);
            if (launch_half && k >= 0) begin
                exp_oe = live && ins && !(companded && seven_bit && lst);
                chk(dx_oe === exp_oe, req, $sformatf("dx_oe k=%0d", k), int'(dx_oe), int'(exp_oe));
                if (exp_oe)
                    chk(dx === exp_tx[blen-1-pos], req, $sformatf("dx k=%0d", k), int'(dx), int'(exp_tx[blen-1-pos]));
            end
            wclk(1);
        end
        fsync = 1'b0; bclk = 1'b0;
        wclk(4);
        if (companded) begin
            exp_rx = {6'b0, drw[7:0]};
            if (seven_bit) exp_rx[0] = 1'b0;
        end else exp_rx = drw;
        chk(take_cnt == 1, "R11", "tx_take pulses per frame", take_cnt, 1);
        if (live) begin
            chk(rx_cnt == 1, "R10", "rx_valid pulses", rx_cnt, 1);
            chk(rx_seen === exp_rx, req, "rx_word", int'(rx_seen), int'(exp_rx));
            last_rx = exp_rx;
        end else begin
            chk(rx_cnt == 0, req, "rx_valid pulses when not live", rx_cnt, 0);
        end
    endtask

    task automatic t_reset;
        wclk(3);
        chk(dx_oe === 1'b0, "R1", "dx_oe after reset", int'(dx_oe), 0);
        chk(rx_valid === 1'b0, "R1", "rx_valid after reset", int'(rx_valid), 0);
        chk(rx_word === 14'h0, "R1", "rx_word after reset", int'(rx_word), 0);
    endtask

    task automatic t_powerup;
        companded = 0; tmode = 2'b10; port_en = 1; pwr_up = 1;
        wclk(4);
        run_frame(1, 14'h2A5C, 14'h1B3D, "R9");   // first pulse: silent
        run_frame(1, 14'h2A5C, 14'h1B3D, "R9");   // second pulse: live
    endtask

    task automatic t_linear;
        companded = 0; tmode = 2'b10; sel_b2 = 1; layout2 = 1; seven_bit = 1;
        run_frame(1, 14'h3FC1, 14'h0E72, "R4");
        run_frame(11, 14'h1234, 14'h2DCB, "R2");  // square-wave frame sync
        sel_b2 = 0; layout2 = 0; seven_bit = 0;
    endtask

    task automatic t_companded;
        companded = 1; tmode = 2'b00;
        sel_b2 = 0; layout2 = 0;
        run_frame(1, 14'h00A7, 14'h00C3, "R3");
        sel_b2 = 1; layout2 = 0;
        run_frame(1, 14'h3F5E, 14'h0091, "R5");
        sel_b2 = 1; layout2 = 1;
        run_frame(2, 14'h0069, 14'h00B4, "R5");
    endtask

    task automatic t_reverse;
        companded = 1; tmode = 2'b11; sel_b2 = 1; layout2 = 1;
        run_frame(1, 14'h00D2, 14'h004B, "R3");
        companded = 0; sel_b2 = 0; layout2 = 0;
        run_frame(1, 14'h19E6, 14'h2571, "R3");
        tmode = 2'b10;
    endtask

    task automatic t_seven;
        companded = 1; seven_bit = 1; tmode = 2'b10; sel_b2 = 0;
        run_frame(1, 14'h00FF, 14'h00A5, "R7");
        seven_bit = 0;
    endtask

    task automatic t_loop;
        companded = 0; tmode = 2'b10; loopback = 1;
        run_frame(1, 14'h0000, 14'h1C39, "R8");
        run_frame(1, 14'h0000, 14'h2E47, "R8");
        loopback = 0;
    endtask

    task automatic t_disabled;
        port_en = 0;
        run_frame(1, 14'h3333, 14'h1111, "R6");
        port_en = 1;
        run_frame(1, 14'h0F0F, 14'h30C3, "R6");
    endtask

    task automatic t_powerdown;
        pwr_up = 0; fs_pulses = 0;
        wclk(6);
        chk(dx_oe === 1'b0, "R1", "dx_oe powered down", int'(dx_oe), 0);
        pwr_up = 1;
        wclk(4);
        run_frame(1, 14'h2222, 14'h0555, "R9");
        run_frame(1, 14'h2222, 14'h0555, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wclk(4);
        rst_n = 1'b1;
        t_reset();
        t_powerup();
        t_linear();
        t_companded();
        t_reverse();
        t_seven();
        t_loop();
        t_disabled();
        t_powerdown();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule